// File: doc/BRIEF.md
# Delay Card Host Register Slave

This block is the host-side register slave of a sample delay card. It decodes a 16-bit synchronous register bus into two address spaces. The register space holds a bucket-delay value and a change-notch value, which feed the card's address counters. It also holds a card-ID value that drives two decimal indicator digits, and a read-only stop-address value. The memory space routes host accesses to two external windows: the sample store and the offset table.

The block tracks whether the card is operating or in stand-by. Two active-low trigger inputs control this. When the card leaves operating mode through the stop trigger, the block captures the input address counter value, which the host can then read back. While the card is operating, the sample store belongs to the datapath, so the block locks host accesses to it out. Everything else stays accessible in both modes.

Bus timing: a read strobe in cycle N loads `rdata_o` at the clock edge that ends cycle N, and `rdata_o` then holds until the next read. A write takes effect at the edge that ends its strobe cycle. The window select, write-enable, address and data outputs are combinational from the bus inputs.

Top module: `dly_host_regs`

## Requirements
- R1: After reset, `operating_o` is 0, and the bucket-delay, change-notch, card-ID and stop-address registers all read 0. Both indicator outputs show the digit 0 (segment code 0x3F).
- R2: In the register space (`reg_space_i`=1), the bucket-delay register sits at byte offset 0x20 and the change-notch register at 0x22. Both hold 16 bits, are writable and readable in either mode, and appear on `bucket_dly_o` and `notch_dly_o`. Address bit 0 is ignored.
- R3: The card-ID register sits at offset 0x24 and reads back all 16 bits. Bits 3:0 drive `seg_lo_o` and bits 7:4 drive `seg_hi_o`. Bits 15:8 have no effect on either indicator.
- R4: Indicator encoding uses bit 0 for segment a through bit 6 for segment g. The codes are: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F. A digit value above nine gives 0x00 (blank).
- R5: A low `start_ni` with `stop_ni` high sets `operating_o` to 1 at the next edge. A low `stop_ni` clears it at the next edge.
- R6: When both triggers are low in the same cycle, stop wins and `operating_o` is 0 after that edge.
- R7: A low `stop_ni` while operating loads `stop_addr_i` into the stop-address register, which is read at offset 0x28. In every other cycle, the stop-address register holds its value.
- R8: Host writes to offset 0x28 are ignored. Register-space reads at any other unlisted offset return 0.
- R9: In stand-by, a memory-space access at byte address below 0x4000 asserts `sample_sel_o`, with `win_addr_o` = address[13:1]. A read returns `sample_rdata_i`, and a write asserts `win_we_o` with `win_wdata_o` = write data.
- R10: While operating, a sample-store access is locked out. `sample_sel_o` and `win_we_o` stay 0, and a read returns 0.
- R11: In both modes, a memory-space access from 0x4000 to 0x47FF asserts `table_sel_o`, with `win_addr_o` = (address-0x4000)>>1. A read returns `table_rdata_i`, and a write asserts `win_we_o`.
- R12: A memory-space read at 0x4800 or above returns 0 and asserts no window select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_ni | input | 1 | Start trigger, active low |
| stop_ni | input | 1 | Stop trigger, active low |
| stop_addr_i | input | 13 | Input address counter value, captured on stop |
| reg_space_i | input | 1 | 1 = register space, 0 = memory space |
| addr_i | input | 16 | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, loaded on a read strobe |
| operating_o | output | 1 | 1 = operating, 0 = stand-by |
| bucket_dly_o | output | 16 | Bucket-delay register value |
| notch_dly_o | output | 16 | Change-notch register value |
| seg_lo_o | output | 7 | Indicator for card-ID bits 3:0 |
| seg_hi_o | output | 7 | Indicator for card-ID bits 7:4 |
| sample_sel_o | output | 1 | Sample-store window access |
| table_sel_o | output | 1 | Offset-table window access |
| win_we_o | output | 1 | Window write enable |
| win_addr_o | output | 13 | Window word address |
| win_wdata_o | output | 16 | Window write data |
| sample_rdata_i | input | 16 | Sample-store read data |
| table_rdata_i | input | 16 | Offset-table read data |

## Verification
Random traffic covers every register offset, the three memory-space regions and trigger pulses, so decode and mode gating are exercised together. Sample-store accesses made in both modes show whether the lockout depends on the mode flag, and not merely on the address. Stop pulses in stand-by and in operating mode, and the case of both triggers at once, show whether capture and priority are correct. Card-ID values with a random upper byte and nibbles above nine show whether the indicator slicing and blanking are right.

// File: rtl/dly_host_pkg.sv
package dly_host_pkg;
  localparam int unsigned ADDR_W       = 16;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned STOP_W       = 13;
  localparam int unsigned SAMPLE_WORDS = 8192;
  localparam int unsigned TABLE_WORDS  = 1024;
  localparam int unsigned TABLE_BASE   = 'h4000;
  localparam int unsigned SEG_W        = 7;

  localparam logic [ADDR_W-1:0] OFS_BUCKET = 16'h0020;
  localparam logic [ADDR_W-1:0] OFS_NOTCH  = 16'h0022;
  localparam logic [ADDR_W-1:0] OFS_ID     = 16'h0024;
  localparam logic [ADDR_W-1:0] OFS_STOP   = 16'h0028;

  typedef enum logic [2:0] {
    REG_NONE, REG_BUCKET, REG_NOTCH, REG_ID, REG_STOP
  } reg_sel_e;
endpackage

// File: rtl/dly_mode_ctl.sv
module dly_mode_ctl #(
  parameter int unsigned STOP_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ni,
  input  logic              stop_ni,
  input  logic [STOP_W-1:0] stop_addr_i,
  output logic              operating_o,
  output logic [STOP_W-1:0] stop_q_o
);
  logic              oper_q;
  logic [STOP_W-1:0] stop_q;
  logic              leave;

  assign leave = oper_q && !stop_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oper_q <= 1'b0;
      stop_q <= '0;
    end else begin
      if (!stop_ni)       oper_q <= 1'b0;   // stop has priority
      else if (!start_ni) oper_q <= 1'b1;
      if (leave) stop_q <= stop_addr_i;
    end
  end

  assign operating_o = oper_q;
  assign stop_q_o    = stop_q;

  assert_start_enters_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ni && !start_ni) |=> oper_q);
  assert_stop_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_ni |=> !oper_q);
  assert_stop_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !leave |=> $stable(stop_q));
endmodule

// File: rtl/dly_addr_dec.sv
module dly_addr_dec
  import dly_host_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned S_WORDS = SAMPLE_WORDS,
  parameter int unsigned T_WORDS = TABLE_WORDS,
  parameter int unsigned T_BASE  = TABLE_BASE,
  localparam int unsigned WAW    = $clog2(S_WORDS)
) (
  input  logic           reg_space_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           operating_i,
  output reg_sel_e       reg_sel_o,
  output logic           sample_hit_o,
  output logic           table_hit_o,
  output logic [WAW-1:0] win_addr_o
);
  localparam logic [AW-1:0] S_TOP = AW'(S_WORDS * 2);
  localparam logic [AW-1:0] T_LO  = AW'(T_BASE);
  localparam logic [AW-1:0] T_TOP = AW'(T_BASE + T_WORDS * 2);

  logic [AW-1:0] t_ofs;
  logic          s_range;

  assign t_ofs   = addr_i - T_LO;
  assign s_range = !reg_space_i && (addr_i < S_TOP);

  always_comb begin
    reg_sel_o = REG_NONE;
    if (reg_space_i) begin
      unique case (addr_i[AW-1:1])
        OFS_BUCKET[AW-1:1]: reg_sel_o = REG_BUCKET;
        OFS_NOTCH[AW-1:1]:  reg_sel_o = REG_NOTCH;
        OFS_ID[AW-1:1]:     reg_sel_o = REG_ID;
        OFS_STOP[AW-1:1]:   reg_sel_o = REG_STOP;
        default:            reg_sel_o = REG_NONE;
      endcase
    end
  end

  assign sample_hit_o = s_range && !operating_i;
  assign table_hit_o  = !reg_space_i && (addr_i >= T_LO) && (addr_i < T_TOP);
  assign win_addr_o   = s_range ? addr_i[WAW:1] : t_ofs[WAW:1];
endmodule

// File: rtl/dly_reg_file.sv
module dly_reg_file
  import dly_host_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = STOP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  reg_sel_e      reg_sel_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] stop_q_i,
  output logic [DW-1:0] bucket_o,
  output logic [DW-1:0] notch_o,
  output logic [DW-1:0] card_id_o,
  output logic [DW-1:0] reg_rdata_o
);
  logic [DW-1:0] bucket_q, notch_q, id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bucket_q <= '0;
      notch_q  <= '0;
      id_q     <= '0;
    end else if (wr_i) begin
      if (reg_sel_i == REG_BUCKET) bucket_q <= wdata_i;
      if (reg_sel_i == REG_NOTCH)  notch_q  <= wdata_i;
      if (reg_sel_i == REG_ID)     id_q     <= wdata_i;
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      REG_BUCKET: reg_rdata_o = bucket_q;
      REG_NOTCH:  reg_rdata_o = notch_q;
      REG_ID:     reg_rdata_o = id_q;
      REG_STOP:   reg_rdata_o = DW'(stop_q_i);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign bucket_o  = bucket_q;
  assign notch_o   = notch_q;
  assign card_id_o = id_q;

  assert_bucket_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && reg_sel_i == REG_BUCKET) |=> $stable(bucket_q));
endmodule

// File: rtl/dly_digit_dec.sv
module dly_digit_dec #(
  parameter int unsigned SEG_W = 7
) (
  input  logic [3:0]       digit_i,
  output logic [SEG_W-1:0] seg_o
);
  always_comb begin
    unique case (digit_i)
      4'd0:    seg_o = SEG_W'(7'h3F);
      4'd1:    seg_o = SEG_W'(7'h06);
      4'd2:    seg_o = SEG_W'(7'h5B);
      4'd3:    seg_o = SEG_W'(7'h4F);
      4'd4:    seg_o = SEG_W'(7'h66);
      4'd5:    seg_o = SEG_W'(7'h6D);
      4'd6:    seg_o = SEG_W'(7'h7D);
      4'd7:    seg_o = SEG_W'(7'h07);
      4'd8:    seg_o = SEG_W'(7'h7F);
      4'd9:    seg_o = SEG_W'(7'h6F);
      default: seg_o = '0;   // above nine: blank
    endcase
  end
endmodule

// File: rtl/dly_host_regs.sv
module dly_host_regs
  import dly_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ni,
  input  logic              stop_ni,
  input  logic [STOP_W-1:0] stop_addr_i,
  input  logic              reg_space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              operating_o,
  output logic [DATA_W-1:0] bucket_dly_o,
  output logic [DATA_W-1:0] notch_dly_o,
  output logic [SEG_W-1:0]  seg_lo_o,
  output logic [SEG_W-1:0]  seg_hi_o,
  output logic              sample_sel_o,
  output logic              table_sel_o,
  output logic              win_we_o,
  output logic [$clog2(SAMPLE_WORDS)-1:0] win_addr_o,
  output logic [DATA_W-1:0] win_wdata_o,
  input  logic [DATA_W-1:0] sample_rdata_i,
  input  logic [DATA_W-1:0] table_rdata_i
);
  localparam int unsigned N_DIGITS = 2;

  logic              oper;
  logic [STOP_W-1:0] stop_q;
  reg_sel_e          reg_sel;
  logic              s_hit, t_hit, acc;
  logic [DATA_W-1:0] card_id, reg_rdata, rd_mux, rdata_q;
  logic [SEG_W-1:0]  seg [N_DIGITS];

  dly_mode_ctl #(.STOP_W(STOP_W)) u_mode (
    .clk_i, .rst_ni, .start_ni, .stop_ni, .stop_addr_i,
    .operating_o(oper), .stop_q_o(stop_q)
  );

  dly_addr_dec u_dec (
    .reg_space_i, .addr_i, .operating_i(oper),
    .reg_sel_o(reg_sel), .sample_hit_o(s_hit), .table_hit_o(t_hit),
    .win_addr_o
  );

  dly_reg_file u_regs (
    .clk_i, .rst_ni, .reg_sel_i(reg_sel), .wr_i, .wdata_i,
    .stop_q_i(stop_q), .bucket_o(bucket_dly_o), .notch_o(notch_dly_o),
    .card_id_o(card_id), .reg_rdata_o(reg_rdata)
  );

  for (genvar d = 0; d < N_DIGITS; d++) begin : g_digit
    dly_digit_dec #(.SEG_W(SEG_W)) u_digit (
      .digit_i(card_id[4*d +: 4]), .seg_o(seg[d])
    );
  end

  assign seg_lo_o = seg[0];
  assign seg_hi_o = seg[1];

  assign acc          = rd_i || wr_i;
  assign sample_sel_o = acc && s_hit;
  assign table_sel_o  = acc && t_hit;
  assign win_we_o     = wr_i && (s_hit || t_hit);
  assign win_wdata_o  = wdata_i;

  always_comb begin
    if (reg_space_i) rd_mux = reg_rdata;
    else if (s_hit)  rd_mux = sample_rdata_i;
    else if (t_hit)  rd_mux = table_rdata_i;
    else             rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o     = rdata_q;
  assign operating_o = oper;

  assert_sample_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oper |-> !sample_sel_o);
  assert_one_window_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_sel_o, table_sel_o}));
endmodule

// File: tb/dly_host_regs_bench.sv
module dly_host_regs_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_ni = 1'b1, stop_ni = 1'b1;
  logic [12:0] stop_addr_i = '0;
  logic        reg_space_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [15:0] rdata_o, bucket_dly_o, notch_dly_o, win_wdata_o;
  logic        operating_o, sample_sel_o, table_sel_o, win_we_o;
  logic [6:0]  seg_lo_o, seg_hi_o;
  logic [12:0] win_addr_o;
  logic [15:0] sample_rdata_i, table_rdata_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_bucket = 0, m_notch = 0, m_id = 0;
  logic [12:0] m_stop = 0;
  bit          m_oper = 0;

  always #5 clk_i = ~clk_i;

  function automatic logic [15:0] smem(logic [12:0] a);
    return {3'b000, a} ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] tmem(logic [12:0] a);
    return {6'b0, a[9:0]} * 16'd3 + 16'h0100;
  endfunction
  function automatic logic [6:0] seg_of(logic [3:0] v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction
  function automatic logic [15:0] exp_read(bit sp, logic [15:0] a);
    if (sp) begin
      case (a & 16'hFFFE)
        16'h20: return m_bucket;
        16'h22: return m_notch;
        16'h24: return m_id;
        16'h28: return {3'b0, m_stop};
        default: return 16'h0;
      endcase
    end
    if (a < 16'h4000) return m_oper ? 16'h0 : smem(a[13:1]);
    if (a < 16'h4800) return tmem(13'((a - 16'h4000) >> 1));
    return 16'h0;
  endfunction

  assign sample_rdata_i = smem(win_addr_o);
  assign table_rdata_i  = tmem(win_addr_o);

  dly_host_regs u_dly_host_regs (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_write(bit sp, logic [15:0] a, logic [15:0] d);
    reg_space_i = sp; addr_i = a; wdata_i = d; wr_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 0;
    if (sp) case (a & 16'hFFFE)
      16'h20: m_bucket = d;
      16'h22: m_notch = d;
      16'h24: m_id = d;
      default: ;
    endcase
  endtask

  task automatic do_read(string req, bit sp, logic [15:0] a);
    reg_space_i = sp; addr_i = a; rd_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    rd_i = 0;
    chk(req, rdata_o, exp_read(sp, a));
  endtask

  task automatic trig(bit s, bit p);
    logic [12:0] sa = 13'($urandom);
    start_ni = s; stop_ni = p; stop_addr_i = sa;
    @(posedge clk_i); @(negedge clk_i);
    start_ni = 1; stop_ni = 1;
    if (!p) begin
      if (m_oper) m_stop = sa;
      m_oper = 0;
    end else if (!s) m_oper = 1;
    chk(!p && !s ? "R6" : "R5", operating_o, m_oper);
  endtask

  // Combinational window strobes for a memory-space write
  task automatic win_write(logic [15:0] a, logic [15:0] d);
    bit sh = (a < 16'h4000) && !m_oper;
    bit th = (a >= 16'h4000) && (a < 16'h4800);
    reg_space_i = 0; addr_i = a; wdata_i = d; wr_i = 1;
    #1;
    chk(th ? "R11" : (a < 16'h4000 ? (m_oper ? "R10" : "R9") : "R12"),
        {sample_sel_o, table_sel_o, win_we_o}, {sh, th, sh || th});
    if (sh) chk("R9", {win_addr_o, win_wdata_o}, {a[13:1], d});
    if (th) chk("R11", {win_addr_o, win_wdata_o}, {13'((a - 16'h4000) >> 1), d});
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 0;
  endtask

  function automatic logic [15:0] rnd_reg_addr();
    logic [15:0] r;
    case ($urandom % 5)
      0: r = 16'h20; 1: r = 16'h22; 2: r = 16'h24; 3: r = 16'h28;
      default: r = 16'($urandom % 64);
    endcase
    return r | 16'($urandom % 2);
  endfunction
  function automatic logic [15:0] rnd_mem_addr();
    case ($urandom % 3)
      0: return 16'($urandom % 16'h4000);
      1: return 16'h4000 + 16'($urandom % 16'h800);
      default: return 16'h4800 + 16'($urandom % 16'hB800);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", operating_o, 0);
    chk("R1", {seg_hi_o, seg_lo_o}, {7'h3F, 7'h3F});
    do_read("R1", 1, 16'h20); do_read("R1", 1, 16'h22);
    do_read("R1", 1, 16'h24); do_read("R1", 1, 16'h28);
    // R2 in standby
    do_write(1, 16'h20, 16'hE123); do_write(1, 16'h23, 16'h0456);
    chk("R2", {bucket_dly_o, notch_dly_o}, {16'hE123, 16'h0456});
    do_read("R2", 1, 16'h21); do_read("R2", 1, 16'h22);
    // R3/R4 card ID, upper byte ignored, blanking
    do_write(1, 16'h24, 16'hFF47);
    chk("R3", {seg_hi_o, seg_lo_o}, {seg_of(4), seg_of(7)});
    do_read("R3", 1, 16'h24);
    do_write(1, 16'h24, 16'h00A9);
    chk("R4", {seg_hi_o, seg_lo_o}, {7'h00, 7'h6F});
    do_write(1, 16'h24, 16'h5A3F);
    chk("R4", {seg_hi_o, seg_lo_o}, {7'h4F, 7'h00});
    // R8 stop register write ignored, unlisted offset reads 0
    do_write(1, 16'h28, 16'hFFFF);
    do_read("R8", 1, 16'h28);
    do_read("R8", 1, 16'h26);
    // R9 sample store in standby
    win_write(16'h1234, 16'hBEEF);
    do_read("R9", 0, 16'h3FFE);
    // R7 stop while standby does not capture
    trig(1, 0);
    do_read("R7", 1, 16'h28);
    // R5 enter operating, R10 lockout, R11 table, R2 writes while operating
    trig(0, 1);
    win_write(16'h0100, 16'h1111);
    do_read("R10", 0, 16'h0100);
    win_write(16'h47FE, 16'h2222);
    do_read("R11", 0, 16'h4002);
    do_write(1, 16'h20, 16'h0777);
    chk("R2", bucket_dly_o, 16'h0777);
    // R6 both low: stop wins and R7 capture
    trig(0, 0);
    do_read("R7", 1, 16'h28);
    // R12 above table
    win_write(16'h4800, 16'h3333);
    do_read("R12", 0, 16'hFFFE);
    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0: do_write(1, rnd_reg_addr(), 16'($urandom));
        1: do_read("R2", 1, rnd_reg_addr());
        2: trig(bit'($urandom % 3 != 0), bit'($urandom % 3 != 0));
        3: do_read("R9", 0, rnd_mem_addr());
        4: win_write(rnd_mem_addr(), 16'($urandom));
        default: chk("R3", {seg_hi_o, seg_lo_o, bucket_dly_o, notch_dly_o},
                     {seg_of(m_id[7:4]), seg_of(m_id[3:0]), m_bucket, m_notch});
      endcase
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule